// File: doc/BRIEF.md
# On-chip XDATA RAM Access Controller

This block sits between a small 8-bit core and the data-space memory. Each read or write request goes one of two ways. It is either served by a block of on-chip RAM that sits at the top of the 64 KB data space, or it is run as a two-phase cycle on a multiplexed address/data bus. The bus side uses an address-latch strobe and active-low read and write strobes.

A control register holds two bits.

- The RAM-off bit comes out of reset set, so the on-chip RAM is disabled. Software can clear it once. After that only a reset can set it again.
- The debug-visibility bit makes internal accesses also appear on the external bus and strobes, so an analyser can watch them.

An active-low external-access input overrides the RAM and sends every access outside. When the ports are not carrying a bus cycle they pass the core's port output latches.

Every accepted request occupies the block for two further clock cycles. The first is the address phase and the second is the strobe phase. Requests raised during those cycles are ignored.

Top module: `xram_access_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x01: bit 0 (RAM-off) is 1 and bit 1 (debug) is 0. After reset `ale` is 0 and `rd_n` and `wr_n` are 1.
- R2: A control write with bit 0 equal to 0 clears RAM-off. A later write with bit 0 equal to 1 leaves it at 0. Only a reset sets it again.
- R3: Repeated writes of 0 to bit 0 leave RAM-off at 0. Bit 1 (debug) takes the written value on every control write. Both bits read back on `cfg_rdata` one cycle after the write.
- R4: A request is internal exactly when RAM-off is 0, `ext_acc_n` is 1 and `req_addr[15:8]` is 0xFF. Every other request is external.
- R5: During an internal access with debug 0, `ale` stays 0 and `rd_n` and `wr_n` stay 1 in both phases. During that time `p0_o`/`p2_o` show `p0_latch`/`p2_latch`.
- R6: During an internal access with debug 1, the bus cycle of R7 is run. In the strobe phase of a write, `p0_o` carries the write data.
- R7: In an external access, the cycle after acceptance has `ale`=1, `p0_o`=address bits 7:0 and `p2_o`=address bits 15:8. The next cycle has `ale`=0 and `p2_o` still showing the high address. In that cycle a write drives `wr_n`=0 and puts the data on `p0_o` with `p0_oe`=1. A read drives `rd_n`=0 with `p0_oe`=0.
- R8: Read data for an internal read appears on `rdata` after the accepting clock edge. `p_data_i` is never sampled for that access, even in debug mode.
- R9: Read data for an external read is `p_data_i` as sampled at the edge that ends the strobe phase.
- R10: When no bus phase is active, `p0_o`=`p0_latch`, `p2_o`=`p2_latch` and `p0_oe`=1.
- R11: A request held high during the address or strobe phase of an earlier access is ignored. It does not start a new cycle and does not write the RAM.
- R12: Internal writes update the RAM. External writes, including those to window addresses, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, accepted when the block is idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space address |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Read data register |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data (bit 0 RAM-off, bit 1 debug) |
| cfg_rdata | output | 8 | Control register readback |
| ext_acc_n | input | 1 | Active-low force-external input |
| p0_latch | input | 8 | Low port output latch |
| p2_latch | input | 8 | High port output latch |
| p_data_i | input | 8 | Data read from the external bus |
| p0_o | output | 8 | Low port output: address low / data / latch |
| p0_oe | output | 1 | Low port output enable |
| p2_o | output | 8 | High port output: address high / latch |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions check the following on every cycle:

- the RAM-off bit never rises outside reset;
- the two strobes are never low together;
- a strobe always follows an address phase, lasts one cycle, and no two address phases are adjacent;
- a hidden internal access never moves a strobe;
- the ports carry the latches whenever no bus phase is active.

Some behaviour only the bench's scenarios can show:

- the routing decision;
- the address and data values on the ports;
- read data from RAM versus bus;
- that external and ignored writes leave the RAM contents intact.

The bench shows these by comparing against a model that tracks the control bits and the RAM.

// File: rtl/xram_pkg.sv
// Package: shared types and constants of the XDATA access controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package xram_pkg;

    // Phase of the bus sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2
    } bus_phase_e;

    // Bit positions inside the control register.
    localparam int unsigned CFG_OFF_BIT = 0;
    localparam int unsigned CFG_DBG_BIT = 1;

endpackage

// File: rtl/xram_sysctl.sv
// Module: control register holding the one-way RAM-off latch and the
// debug-visibility bit.
// Assumes: cfg_we is a one-cycle write strobe from the core.
module xram_sysctl
    import xram_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              ram_off,
    output logic              dbg_vis,
    output logic [DATA_W-1:0] cfg_rdata
);

    logic off_q;
    logic dbg_q;

    // Control state: RAM-off may only fall under software, rises only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= 1'b1;
            dbg_q <= 1'b0;
        end else if (cfg_we) begin
            if (!cfg_wdata[CFG_OFF_BIT]) begin
                off_q <= 1'b0;
            end
            dbg_q <= cfg_wdata[CFG_DBG_BIT];
        end
    end

    // Readback: assemble the register image.
    always_comb begin
        cfg_rdata              = '0;
        cfg_rdata[CFG_OFF_BIT] = off_q;
        cfg_rdata[CFG_DBG_BIT] = dbg_q;
    end

    assign ram_off = off_q;
    assign dbg_vis = dbg_q;

endmodule

// File: rtl/xram_decode.sv
// Module: decides whether a request is served by the on-chip RAM and
// whether it is shown on the external bus.
// Assumes: the RAM window is the top 2**WIN_AW bytes of the data space.
module xram_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned WIN_AW = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ram_off,
    input  logic              ext_acc_n,
    input  logic              dbg_vis,
    output logic              hit_int,
    output logic              show_bus,
    output logic [WIN_AW-1:0] win_idx
);

    localparam int unsigned TAG_W = ADDR_W - WIN_AW;

    logic in_window;

    // Window match: all upper address bits set.
    always_comb begin
        in_window = (addr[ADDR_W-1:WIN_AW] == {TAG_W{1'b1}});
    end

    // Routing: internal only with RAM enabled and no external force.
    always_comb begin
        hit_int  = in_window && !ram_off && ext_acc_n;
        show_bus = !hit_int || dbg_vis;
        win_idx  = addr[WIN_AW-1:0];
    end

endmodule

// File: rtl/xram_store.sv
// Module: on-chip XDATA RAM, one port, synchronous write, combinational read.
// Assumes: contents are undefined after power-up and are not reset.
module xram_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage write on an accepted internal write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    // Read path: addressed word.
    always_comb begin
        rdata = mem[idx];
    end

endmodule

// File: rtl/xram_bus_seq.sv
// Module: two-phase multiplexed bus sequencer. It runs an address phase
// and then a strobe phase for every accepted request, and drives the
// ports from the latches when no phase is visible.
// Assumes: start is only raised while idle is high.
module xram_bus_seq
    import xram_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     wr,
    input  logic                     internal,
    input  logic                     show,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W-1:0]        p0_latch,
    input  logic [ADDR_W-DATA_W-1:0] p2_latch,
    output logic                     idle,
    output logic                     shown,
    output logic                     ext_rd_cap,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        p0_o,
    output logic                     p0_oe,
    output logic [ADDR_W-DATA_W-1:0] p2_o
);

    localparam int unsigned HI_W = ADDR_W - DATA_W;

    bus_phase_e        phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q;
    logic              wr_q;
    logic              int_q;
    logic              show_q;

    // Phase progression: idle -> address -> strobe -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) phase_q <= PH_ADDR;
                PH_ADDR: phase_q <= PH_STRB;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Transfer capture: hold the request attributes for both phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wd_q   <= '0;
            wr_q   <= 1'b0;
            int_q  <= 1'b0;
            show_q <= 1'b0;
        end else if (start && phase_q == PH_IDLE) begin
            addr_q <= addr;
            wd_q   <= wdata;
            wr_q   <= wr;
            int_q  <= internal;
            show_q <= show;
        end
    end

    // Status toward the top: idle flag, visibility and bus capture pulse.
    always_comb begin
        idle       = (phase_q == PH_IDLE);
        shown      = show_q && !idle;
        ext_rd_cap = (phase_q == PH_STRB) && !wr_q && !int_q;
    end

    // Port and strobe drive for the current phase.
    always_comb begin
        ale   = 1'b0;
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        p0_o  = p0_latch;
        p0_oe = 1'b1;
        p2_o  = p2_latch;
        if (show_q && phase_q == PH_ADDR) begin
            ale  = 1'b1;
            p0_o = addr_q[DATA_W-1:0];
            p2_o = addr_q[ADDR_W-1:DATA_W];
        end else if (show_q && phase_q == PH_STRB) begin
            p2_o = addr_q[ADDR_W-1:DATA_W];
            if (wr_q) begin
                wr_n = 1'b0;
                p0_o = wd_q;
            end else begin
                rd_n  = 1'b0;
                p0_oe = 1'b0;
                p0_o  = {DATA_W{1'b0}};
            end
        end
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;

endmodule

// File: rtl/xram_access_ctrl.sv
// Module: top of the XDATA access controller. It accepts core requests
// while idle, routes them to the on-chip RAM or the external bus, and
// keeps the read data register.
// Assumes: the core holds request fields stable in the cycle it raises req.
module xram_access_ctrl #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WIN_AW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     req_wr,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic                     cfg_we,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic [DATA_W-1:0]        cfg_rdata,
    input  logic                     ext_acc_n,
    input  logic [DATA_W-1:0]        p0_latch,
    input  logic [ADDR_W-DATA_W-1:0] p2_latch,
    input  logic [DATA_W-1:0]        p_data_i,
    output logic [DATA_W-1:0]        p0_o,
    output logic                     p0_oe,
    output logic [ADDR_W-DATA_W-1:0] p2_o,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n
);

    logic              ram_off;
    logic              dbg_vis;
    logic              hit_int;
    logic              show_bus;
    logic [WIN_AW-1:0] win_idx;
    logic              seq_idle;
    logic              bus_shown;
    logic              ext_rd_cap;
    logic              accept;
    logic              ram_we;
    logic [DATA_W-1:0] ram_q;
    logic [DATA_W-1:0] rdata_q;

    xram_sysctl #(.DATA_W(DATA_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ram_off   (ram_off),
        .dbg_vis   (dbg_vis),
        .cfg_rdata (cfg_rdata)
    );

    xram_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_dec (
        .addr      (req_addr),
        .ram_off   (ram_off),
        .ext_acc_n (ext_acc_n),
        .dbg_vis   (dbg_vis),
        .hit_int   (hit_int),
        .show_bus  (show_bus),
        .win_idx   (win_idx)
    );

    // Acceptance: a request counts only while the sequencer is idle.
    always_comb begin
        accept = req && seq_idle;
        ram_we = accept && req_wr && hit_int;
    end

    xram_store #(.DATA_W(DATA_W), .AW(WIN_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (win_idx),
        .wdata (req_wdata),
        .rdata (ram_q)
    );

    xram_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .wr         (req_wr),
        .internal   (hit_int),
        .show       (show_bus),
        .addr       (req_addr),
        .wdata      (req_wdata),
        .p0_latch   (p0_latch),
        .p2_latch   (p2_latch),
        .idle       (seq_idle),
        .shown      (bus_shown),
        .ext_rd_cap (ext_rd_cap),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .p0_o       (p0_o),
        .p0_oe      (p0_oe),
        .p2_o       (p2_o)
    );

    // Read data: RAM word on internal read, bus value at end of strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept && !req_wr && hit_int) begin
            rdata_q <= ram_q;
        end else if (ext_rd_cap) begin
            rdata_q <= p_data_i;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/xram_access_chk.sv
// Module: assertion checker for xram_access_ctrl, attached by bind.
// Assumes: connected to the top module's ports and sequencer status.
module xram_access_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [DATA_W-1:0]        cfg_rdata,
    input logic                     ale,
    input logic                     rd_n,
    input logic                     wr_n,
    input logic [DATA_W-1:0]        p0_o,
    input logic                     p0_oe,
    input logic [ADDR_W-DATA_W-1:0] p2_o,
    input logic [DATA_W-1:0]        p0_latch,
    input logic [ADDR_W-DATA_W-1:0] p2_latch,
    input logic                     seq_idle,
    input logic                     bus_shown
);

    // R2: RAM-off never rises again outside reset.
    p_one_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |=> !cfg_rdata[0]);

    // R7: the two strobes are never active together.
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R7: a strobe is always preceded by an address phase.
    p_addr_before_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $past(ale));

    // R7: a strobe lasts one cycle.
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |=> (rd_n && wr_n));

    // R11: no new address phase directly after an address phase.
    p_no_back_to_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R5: a hidden internal access moves neither strobe nor address latch.
    p_hidden_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && !bus_shown) |-> (rd_n && wr_n && !ale));

    // R10: with no bus phase visible the ports carry the latches.
    p_io_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n && !ale) |-> (p0_o == p0_latch && p2_o == p2_latch && p0_oe));

endmodule

bind xram_access_ctrl xram_access_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .p0_o      (p0_o),
    .p0_oe     (p0_oe),
    .p2_o      (p2_o),
    .p0_latch  (p0_latch),
    .p2_latch  (p2_latch),
    .seq_idle  (seq_idle),
    .bus_shown (bus_shown)
);

// File: tb/sim_xram_access_ctrl.sv
module sim_xram_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rdata;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        ext_acc_n = 1'b1;
    logic [7:0]  p0_latch = 8'h3C;
    logic [7:0]  p2_latch = 8'hC3;
    logic [7:0]  p_data_i = '0;
    logic [7:0]  p0_o;
    logic        p0_oe;
    logic [7:0]  p2_o;
    logic        ale;
    logic        rd_n;
    logic        wr_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state.
    bit         m_off = 1'b1;
    bit         m_dbg = 1'b0;
    logic [7:0] m_ram [256];

    always #5 clk = ~clk;

    xram_access_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rdata(rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ext_acc_n(ext_acc_n), .p0_latch(p0_latch),
        .p2_latch(p2_latch), .p_data_i(p_data_i), .p0_o(p0_o), .p0_oe(p0_oe),
        .p2_o(p2_o), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_int(input logic [15:0] a, input bit off, input logic xn);
        return (a[15:8] == 8'hFF) && !off && (xn == 1'b1);
    endfunction

    task automatic cfg_write(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        if (!d[0]) m_off = 1'b0;
        m_dbg = d[1];
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R3 cfg readback", 32'(cfg_rdata), 32'({6'b0, m_dbg, m_off}));
    endtask

    // One full access: drive, then check address phase, strobe phase, idle.
    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] wd, input bit hold);
        bit ie, se;
        logic [7:0] bus;
        @(negedge clk);
        p0_latch = 8'($urandom);
        p2_latch = 8'($urandom);
        bus = 8'($urandom);
        p_data_i = bus;
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
        ie = exp_int(a, m_off, ext_acc_n);
        se = !ie || m_dbg;
        @(negedge clk);
        if (hold) begin
            req_addr = a ^ 16'h0001;
            req_wdata = ~wd;
        end else begin
            req = 1'b0;
        end
        chk("R4/R7 ale in address phase", 32'(ale), 32'(se));
        if (se) begin
            chk("R6/R7 p0 address low", 32'(p0_o), 32'(a[7:0]));
            chk("R6/R7 p2 address high", 32'(p2_o), 32'(a[15:8]));
        end else begin
            chk("R5 p0 latch while hidden", 32'(p0_o), 32'(p0_latch));
            chk("R5 p2 latch while hidden", 32'(p2_o), 32'(p2_latch));
        end
        if (ie && !wr) chk("R8 internal read data", 32'(rdata), 32'(m_ram[a[7:0]]));
        @(negedge clk);
        chk("R5/R7 rd_n strobe", 32'(rd_n), 32'(!(se && !wr)));
        chk("R5/R7 wr_n strobe", 32'(wr_n), 32'(!(se && wr)));
        chk("R7 ale low in strobe phase", 32'(ale), 32'd0);
        if (se) begin
            chk("R7 p2 holds high address", 32'(p2_o), 32'(a[15:8]));
            if (wr) chk("R6/R7 write data on p0", 32'(p0_o), 32'(wd));
            chk("R7 p0 drive enable", 32'(p0_oe), 32'(wr));
        end else begin
            chk("R5 p0 latch in strobe phase", 32'(p0_o), 32'(p0_latch));
        end
        if (ie && wr) m_ram[a[7:0]] = wd;
        @(negedge clk);
        req = 1'b0;
        chk("R10 p0 latch idle", 32'(p0_o), 32'(p0_latch));
        chk("R10 p2 latch idle", 32'(p2_o), 32'(p2_latch));
        chk("R10 p0_oe idle", 32'(p0_oe), 32'd1);
        chk("R11 no new address phase", 32'(ale), 32'd0);
        if (!wr) begin
            if (ie) chk("R8 bus not sampled", 32'(rdata), 32'(m_ram[a[7:0]]));
            else    chk("R9 external read data", 32'(rdata), 32'(bus));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = 1'b0;
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_off = 1'b1;
        m_dbg = 1'b0;
        chk("R1 cfg reset value", 32'(cfg_rdata), 32'h01);
        chk("R1 strobes idle", 32'({ale, rd_n, wr_n}), 32'b011);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R4: window access while RAM is off goes outside.
        access(1'b1, 16'hFF20, 8'h5A, 1'b0);
        access(1'b0, 16'hFF20, 8'h00, 1'b0);
        // R2/R3: bit 0 set while off; debug bit follows.
        cfg_write(8'h03);
        chk("R2 still off", 32'(cfg_rdata[0]), 32'd1);
        cfg_write(8'h00);
        chk("R2 enabled", 32'(cfg_rdata[0]), 32'd0);
        cfg_write(8'h01);
        chk("R2 one-way stays enabled", 32'(cfg_rdata[0]), 32'd0);
        cfg_write(8'h00);
        chk("R3 repeated clear", 32'(cfg_rdata[0]), 32'd0);
        // R12/R5: fill the RAM through hidden internal writes.
        for (int i = 0; i < 256; i++) access(1'b1, {8'hFF, 8'(i)}, 8'(i * 7 + 3), 1'b0);
        // R6/R8: debug visible internal accesses.
        cfg_write(8'h02);
        access(1'b1, 16'hFF40, 8'hE1, 1'b0);
        access(1'b0, 16'hFF40, 8'h00, 1'b0);
        // R4/R12: force-external write must not touch the RAM.
        ext_acc_n = 1'b0;
        access(1'b1, 16'hFF41, 8'h99, 1'b0);
        ext_acc_n = 1'b1;
        access(1'b0, 16'hFF41, 8'h00, 1'b0);
        // R11: request held through both phases is ignored.
        access(1'b1, 16'hFF50, 8'h11, 1'b1);
        access(1'b0, 16'hFF51, 8'h00, 1'b0);
        access(1'b0, 16'hFF50, 8'h00, 1'b0);
        // Random mix.
        for (int n = 0; n < 600; n++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k == 0) begin
                cfg_write(8'($urandom) & 8'h03);
            end else begin
                logic [15:0] a;
                a = ($urandom_range(0, 3) != 0) ? {8'hFF, 8'($urandom)} : 16'($urandom);
                ext_acc_n = ($urandom_range(0, 4) != 0);
                access(1'($urandom), a, 8'($urandom), 1'($urandom_range(0, 7) == 0));
            end
        end
        ext_acc_n = 1'b1;
        // R1/R2: only reset turns the RAM off again.
        do_reset();
        access(1'b1, 16'hFF60, 8'h77, 1'b0);
        access(1'b0, 16'hFF60, 8'h00, 1'b0);
        cfg_write(8'h00);
        access(1'b0, 16'hFF60, 8'h00, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule